// File: doc/BRIEF.md
# Manual Encryption Control Sequencer

This block is the software-facing control and status front end of a manual flash-encryption engine. Software loads a 16-byte plaintext block, chooses a line size (16 or 32 bytes), a target and a physical address, then pulses a start command. The sequencer hands the plaintext, address and line size to an external cipher datapath, pulses its start input, and waits for the datapath's done signal.

A computed result is never exposed to the flash controller straight away. The sequencer has four states: `ST_IDLE` (code 0), `ST_WORK` (code 1, datapath computing), `ST_HELD` (code 2, result present but hidden) and `ST_OPEN` (code 3, result visible to the flash controller). The named transitions are: *launch* (`ST_IDLE` to `ST_WORK` on an accepted start), *finish* (`ST_WORK` to `ST_HELD` on done), *expose* (`ST_HELD` to `ST_OPEN` on a release write) and *discard* (`ST_HELD` or `ST_OPEN` to `ST_IDLE` on a destroy write). Software can read the current state code at any time.

The register interface is a simple 32-bit single-cycle request port. Reads return data one cycle after the request. Start, release and destroy are command bits: they act on the cycle they are written and are never stored.

Top module: `mxe_ctrl`

## Requirements
- R1: After reset the state code reads 0, `result_visible` and `cph_start` are 0, the line-size, target and address registers read 0, and offset 0x5C reads the version value 538969635.
- R2: The plaintext words at offsets 0x00, 0x04, 0x08, 0x0C, the line-size bit (offset 0x40, bit 0), the target bit (offset 0x44, bit 0) and the 30-bit address (offset 0x48, bits [29:0]) read back what was written, with all unused bits reading 0.
- R3: Read data appears on `rd_data` the cycle after the read request. Reads of the command offsets 0x4C, 0x50, 0x54 and of any unmapped offset return 0.
- R4: Writing 1 to bit 0 of offset 0x4C in `ST_IDLE` with an aligned address launches: the state becomes `ST_WORK` and `cph_start` is high for exactly the one cycle after the write.
- R5: A start is ignored when the address is misaligned: with line-size 0 (16 bytes) bits [3:0] must be zero; with line-size 1 (32 bytes) bits [4:0] must be zero.
- R6: A start written in any state other than `ST_IDLE` has no effect and produces no `cph_start` pulse.
- R7: When `cph_done` is high in `ST_WORK`, the state becomes `ST_HELD` at the next edge and `result_visible` stays 0.
- R8: Writing 1 to bit 0 of offset 0x50 in `ST_HELD` moves to `ST_OPEN` and raises `result_visible` from the next cycle; a release in any other state is ignored.
- R9: Writing 1 to bit 0 of offset 0x54 in `ST_HELD` or `ST_OPEN` returns to `ST_IDLE` and drops `result_visible` from the next cycle; a destroy in `ST_IDLE` or `ST_WORK` is ignored.
- R10: Writes to the state offset 0x58, and command writes with bit 0 equal to 0, change nothing.
- R11: `cph_wide` follows the line-size bit, `cph_dest` the target bit, `cph_addr` the address register and `cph_plain` holds plaintext word i at bits [32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read |
| cph_start | output | 1 | One-cycle start pulse to the cipher datapath |
| cph_wide | output | 1 | Line size to the datapath, 1 = 32 bytes |
| cph_dest | output | 1 | Target select to the datapath |
| cph_addr | output | 30 | Physical address to the datapath |
| cph_plain | output | 128 | Plaintext block to the datapath |
| cph_done | input | 1 | Datapath finished |
| result_visible | output | 1 | Result may be used by the flash controller |

## Verification
Every state change, the `cph_start` pulse and `result_visible` are registered once, so each is due in the cycle straight after the clock edge that captured the command or the done pulse, and read data is due one cycle after its request. The bench drives on the falling edge and samples on the next falling edge, which puts each check half a cycle after the edge that should have produced the result. State codes are always read back through offset 0x58, so the state a check sees is the one held at the edge that captured the read. The start pulse is checked both in its one high cycle and in the cycle after.

// File: rtl/mxe_pkg.sv
package mxe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WORK = 2'd1,
        ST_HELD = 2'd2,
        ST_OPEN = 2'd3
    } mxe_state_e;

    localparam int OFS_PLAIN = 'h00;
    localparam int OFS_LSIZE = 'h40;
    localparam int OFS_TGT   = 'h44;
    localparam int OFS_PADDR = 'h48;
    localparam int OFS_GO    = 'h4C;
    localparam int OFS_REL   = 'h50;
    localparam int OFS_KILL  = 'h54;
    localparam int OFS_STATE = 'h58;
    localparam int OFS_VER   = 'h5C;

    localparam logic [29:0] VERSION_DEFAULT = 30'd538969635;

endpackage

// File: rtl/mxe_align.sv
module mxe_align #(
    parameter int PADDR_W    = 30,
    parameter int NARROW_LSB = 4,
    parameter int WIDE_LSB   = 5
) (
    input  logic               wide,
    input  logic [PADDR_W-1:0] paddr,
    output logic               aligned
);
    logic narrow_ok;
    logic wide_ok;

    assign narrow_ok = (paddr[NARROW_LSB-1:0] == '0);
    assign wide_ok   = (paddr[WIDE_LSB-1:0] == '0);
    assign aligned   = wide ? wide_ok : narrow_ok;
endmodule

// File: rtl/mxe_regs.sv
module mxe_regs
    import mxe_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          PT_WORDS = 4,
    parameter int          PADDR_W  = 30,
    parameter logic [29:0] VERSION  = VERSION_DEFAULT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  mxe_state_e                 state_i,
    output logic [DATA_W-1:0]          rd_data,
    output logic [PT_WORDS*DATA_W-1:0] plain,
    output logic                       wide,
    output logic                       dest,
    output logic [PADDR_W-1:0]         paddr,
    output logic                       go_hit,
    output logic                       rel_hit,
    output logic                       kill_hit
);
    localparam int BYTES_W  = $clog2(DATA_W / 8);
    localparam int PT_BYTES = PT_WORDS * (DATA_W / 8);

    logic [DATA_W-1:0] pt_q [PT_WORDS];
    logic              sel_ls, sel_tgt, sel_pa, sel_go, sel_rel, sel_kill, sel_st, sel_ver;
    logic [DATA_W-1:0] rd_next;

    assign sel_ls   = (addr == ADDR_W'(OFS_LSIZE));
    assign sel_tgt  = (addr == ADDR_W'(OFS_TGT));
    assign sel_pa   = (addr == ADDR_W'(OFS_PADDR));
    assign sel_go   = (addr == ADDR_W'(OFS_GO));
    assign sel_rel  = (addr == ADDR_W'(OFS_REL));
    assign sel_kill = (addr == ADDR_W'(OFS_KILL));
    assign sel_st   = (addr == ADDR_W'(OFS_STATE));
    assign sel_ver  = (addr == ADDR_W'(OFS_VER));

    assign go_hit   = wr_en && sel_go   && wdata[0];
    assign rel_hit  = wr_en && sel_rel  && wdata[0];
    assign kill_hit = wr_en && sel_kill && wdata[0];

    generate
        for (genvar w = 0; w < PT_WORDS; w++) begin : g_pt
            localparam int WORD_OFS = OFS_PLAIN + w * (DATA_W / 8);
            logic sel_w;
            assign sel_w = (addr == ADDR_W'(WORD_OFS));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pt_q[w] <= '0;
                end else if (wr_en && sel_w) begin
                    pt_q[w] <= wdata;
                end
            end
            assign plain[w*DATA_W +: DATA_W] = pt_q[w];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide  <= 1'b0;
            dest  <= 1'b0;
            paddr <= '0;
        end else if (wr_en) begin
            if (sel_ls)  wide  <= wdata[0];
            if (sel_tgt) dest  <= wdata[0];
            if (sel_pa)  paddr <= wdata[PADDR_W-1:0];
        end
    end

    always_comb begin
        rd_next = '0;
        if (int'(addr) < OFS_PLAIN + PT_BYTES && addr[BYTES_W-1:0] == '0) begin
            for (int w = 0; w < PT_WORDS; w++) begin
                if (int'(addr) == OFS_PLAIN + w * (DATA_W / 8)) rd_next = pt_q[w];
            end
        end else if (sel_ls) begin
            rd_next = DATA_W'(wide);
        end else if (sel_tgt) begin
            rd_next = DATA_W'(dest);
        end else if (sel_pa) begin
            rd_next = DATA_W'(paddr);
        end else if (sel_st) begin
            rd_next = DATA_W'(state_i);
        end else if (sel_ver) begin
            rd_next = DATA_W'(VERSION);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/mxe_fsm.sv
module mxe_fsm
    import mxe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_hit,
    input  logic       aligned,
    input  logic       done,
    input  logic       rel_hit,
    input  logic       kill_hit,
    output mxe_state_e state,
    output logic       start,
    output logic       visible
);
    mxe_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go_hit && aligned) state_nx = ST_WORK;   // launch
            ST_WORK: if (done)              state_nx = ST_HELD;   // finish
            ST_HELD: begin
                if (kill_hit)               state_nx = ST_IDLE;   // discard
                else if (rel_hit)           state_nx = ST_OPEN;   // expose
            end
            ST_OPEN: if (kill_hit)          state_nx = ST_IDLE;   // discard
            default:                        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start   <= 1'b0;
            visible <= 1'b0;
        end else begin
            start   <= (state == ST_IDLE) && (state_nx == ST_WORK);
            visible <= (state_nx == ST_OPEN);
        end
    end
endmodule

// File: rtl/mxe_ctrl.sv
module mxe_ctrl
    import mxe_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          PT_WORDS = 4,
    parameter int          PADDR_W  = 30,
    parameter logic [29:0] VERSION  = VERSION_DEFAULT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       cph_start,
    output logic                       cph_wide,
    output logic                       cph_dest,
    output logic [PADDR_W-1:0]         cph_addr,
    output logic [PT_WORDS*DATA_W-1:0] cph_plain,
    input  logic                       cph_done,
    output logic                       result_visible
);
    localparam int NARROW_LSB = $clog2(PT_WORDS * DATA_W / 8);
    localparam int WIDE_LSB   = NARROW_LSB + 1;

    mxe_state_e fsm_state;
    logic       wr_en, rd_en;
    logic       go_hit, rel_hit, kill_hit;
    logic       addr_ok;

    assign wr_en = req_valid &&  req_write;
    assign rd_en = req_valid && !req_write;

    mxe_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PT_WORDS(PT_WORDS),
        .PADDR_W (PADDR_W),
        .VERSION (VERSION)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .state_i (fsm_state),
        .rd_data (rd_data),
        .plain   (cph_plain),
        .wide    (cph_wide),
        .dest    (cph_dest),
        .paddr   (cph_addr),
        .go_hit  (go_hit),
        .rel_hit (rel_hit),
        .kill_hit(kill_hit)
    );

    mxe_align #(
        .PADDR_W   (PADDR_W),
        .NARROW_LSB(NARROW_LSB),
        .WIDE_LSB  (WIDE_LSB)
    ) u_align (
        .wide   (cph_wide),
        .paddr  (cph_addr),
        .aligned(addr_ok)
    );

    mxe_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_hit  (go_hit),
        .aligned (addr_ok),
        .done    (cph_done),
        .rel_hit (rel_hit),
        .kill_hit(kill_hit),
        .state   (fsm_state),
        .start   (cph_start),
        .visible (result_visible)
    );
endmodule

// File: rtl/mxe_ctrl_chk.sv
module mxe_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state,
    input logic       start,
    input logic       visible,
    input logic       done,
    input logic       aligned
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);  // R4

    AST_START_IN_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == 2'd1 && $past(state) == 2'd0));  // R4

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(aligned));  // R5

    AST_IDLE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0) |=> (state == 2'd0 || state == 2'd1));  // R6

    AST_WORK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && !done) |=> (state == 2'd1));  // R7

    AST_WORK_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && done) |=> (state == 2'd2 && !visible));  // R7

    AST_VIS_FROM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(visible) |-> ($past(state) == 2'd2));  // R8

    AST_VIS_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(visible) |-> (state == 2'd0));  // R9
endmodule

bind mxe_ctrl mxe_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (fsm_state),
    .start  (cph_start),
    .visible(result_visible),
    .done   (cph_done),
    .aligned(addr_ok)
);

// File: tb/mxe_ctrl_bench.sv
module mxe_ctrl_bench;
    localparam time CLK_T = 20ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  rd_data;
    logic         cph_start, cph_wide, cph_dest, cph_done = 1'b0, result_visible;
    logic [29:0]  cph_addr;
    logic [127:0] cph_plain;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 0;

    always #(CLK_T / 2) clk = ~clk;

    mxe_ctrl u_mxe_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .cph_start(cph_start), .cph_wide(cph_wide), .cph_dest(cph_dest),
        .cph_addr(cph_addr), .cph_plain(cph_plain), .cph_done(cph_done),
        .result_visible(result_visible)
    );

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic chk_state(input string req, input logic [1:0] exp);
        logic [31:0] d;
        rd(8'h58, d);
        chk(req, "state code", d, {30'd0, exp});
    endtask

    task automatic pulse_done();
        @(negedge clk); cph_done = 1'b1;
        @(negedge clk); cph_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "visible after reset", result_visible, 0);
        chk("R1", "start after reset", cph_start, 0);
        chk_state("R1", 2'd0);
        rd(8'h5C, d); chk("R1", "version", d, 32'd538969635);
        rd(8'h40, d); chk("R1", "line size", d, 0);
        rd(8'h44, d); chk("R1", "target", d, 0);
        rd(8'h48, d); chk("R1", "address", d, 0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R2", "line size readback", d, 1);
        chk("R11", "cph_wide", cph_wide, 1);
        wr(8'h44, 32'h0000_0003);
        rd(8'h44, d); chk("R2", "target readback", d, 1);
        chk("R11", "cph_dest", cph_dest, 1);
        wr(8'h48, 32'hFFFF_FFFF);
        rd(8'h48, d); chk("R2", "address readback", d, 32'h3FFF_FFFF);
        chk("R11", "cph_addr", cph_addr, 30'h3FFF_FFFF);
        for (int i = 0; i < 4; i++) wr(8'(4 * i), 32'hA5A5_0000 + 32'(i * 17));
        for (int i = 0; i < 4; i++) begin
            rd(8'(4 * i), d);
            chk("R2", "plaintext readback", d, 32'hA5A5_0000 + 32'(i * 17));
        end
        chk("R11", "cph_plain", cph_plain,
            {32'hA5A5_0033, 32'hA5A5_0022, 32'hA5A5_0011, 32'hA5A5_0000});
        wr(8'h44, 32'h0);
        rd(8'h44, d); chk("R2", "target cleared", d, 0);
    endtask

    task automatic t_read_zero();
        logic [31:0] d;
        rd(8'h4C, d); chk("R3", "go offset reads 0", d, 0);
        rd(8'h50, d); chk("R3", "release offset reads 0", d, 0);
        rd(8'h54, d); chk("R3", "destroy offset reads 0", d, 0);
        rd(8'h10, d); chk("R3", "gap offset reads 0", d, 0);
        rd(8'h60, d); chk("R3", "offset past map reads 0", d, 0);
        rd(8'h02, d); chk("R3", "unaligned offset reads 0", d, 0);
        rd(8'h5C, d); chk("R3", "one-cycle read latency", d, 32'd538969635);
    endtask

    task automatic t_misalign();
        wr(8'h40, 32'h0); wr(8'h48, 32'h0000_0008); wr(8'h4C, 32'h1);
        chk("R5", "no start 16B misaligned", cph_start, 0);
        chk_state("R5", 2'd0);
        wr(8'h40, 32'h1); wr(8'h48, 32'h0000_0010); wr(8'h4C, 32'h1);
        chk("R5", "no start 32B misaligned", cph_start, 0);
        chk_state("R5", 2'd0);
        wr(8'h4C, 32'h0);
        chk("R10", "go with bit0=0", cph_start, 0);
        wr(8'h58, 32'h3);
        chk_state("R10", 2'd0);
    endtask

    task automatic t_flow();
        wr(8'h40, 32'h1); wr(8'h48, 32'h0000_0020);
        wr(8'h4C, 32'h1);
        chk("R4", "start pulse high", cph_start, 1);
        @(negedge clk);
        chk("R4", "start pulse ends", cph_start, 0);
        chk_state("R4", 2'd1);
        wr(8'h4C, 32'h1);
        chk("R6", "no start in WORK", cph_start, 0);
        wr(8'h50, 32'h1); chk_state("R8", 2'd1);
        wr(8'h54, 32'h1); chk_state("R9", 2'd1);
        pulse_done();
        chk("R7", "hidden after done", result_visible, 0);
        chk_state("R7", 2'd2);
        wr(8'h4C, 32'h1);
        chk("R6", "no start in HELD", cph_start, 0);
        chk_state("R6", 2'd2);
        wr(8'h50, 32'h1);
        chk("R8", "visible after release", result_visible, 1);
        chk_state("R8", 2'd3);
        wr(8'h58, 32'h0); chk_state("R10", 2'd3);
        wr(8'h50, 32'h1); chk_state("R8", 2'd3);
        wr(8'h54, 32'h1);
        chk("R9", "hidden after destroy", result_visible, 0);
        chk_state("R9", 2'd0);
    endtask

    task automatic t_destroy_held();
        wr(8'h40, 32'h0); wr(8'h48, 32'h0000_0030);
        wr(8'h4C, 32'h1);
        chk("R4", "start 16B aligned", cph_start, 1);
        pulse_done();
        chk_state("R7", 2'd2);
        wr(8'h54, 32'h0); chk_state("R10", 2'd2);
        wr(8'h54, 32'h1);
        chk_state("R9", 2'd0);
        chk("R9", "still hidden", result_visible, 0);
        wr(8'h50, 32'h1);
        chk("R8", "release in IDLE ignored", result_visible, 0);
        chk_state("R8", 2'd0);
        wr(8'h54, 32'h1); chk_state("R9", 2'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_read_zero();
        t_misalign();
        t_flow();
        t_destroy_held();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_T * 200000);
        if (!ended) begin
            ended = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule